// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Registered Status Flags

This block is the computation stage of a small 16-bit processor. Each cycle it takes two operands and a three-bit operation code from the controller and produces a result combinationally. The supported operations are add, subtract, bitwise AND, bitwise OR, and a one-operand negate. A compare is a subtract whose result is discarded. Negate forms the two's complement of the first operand and ignores the second.

Add, subtract and negate all share one carry-lookahead adder. The operand steering in front of the adder selects what it computes. The logic operations have their own small units.

Four status bits hold the state that conditional jumps test: zero, carry, sign and signed overflow. They are captured in flip-flops. The flip-flops load only on a clock edge where the controller raises the flag-load enable and the operation code is a defined one. At all other times they keep their value, so a flag stays valid across any number of cycles that do not set flags.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 (add) drives the result with A + B modulo 2^16.
- R2: Operation code 1 (subtract) drives the result with A − B modulo 2^16.
- R3: Operation code 2 drives the result with A AND B. Operation code 3 drives it with A OR B.
- R4: Operation code 4 (negate) drives the result with 0 − A modulo 2^16. The B operand has no effect on the result or on the flags.
- R5: Operation codes 5, 6 and 7 drive a result of zero. They never update the flags, even when the flag-load enable is high.
- R6: The flags change only on a rising clock edge where flag_en_i is high and the operation code is 0 to 4. Otherwise all four flags hold their value.
- R7: When the flags load, zero is 1 exactly when all 16 result bits are 0, and sign equals result bit 15.
- R8: When the flags load, carry is set as follows:
  - add: the adder carry-out.
  - subtract: 1 when A ≥ B as unsigned numbers, which is the carry-out of A + ~B + 1.
  - negate: 1 only when A is 0.
  - AND and OR: 0.
- R9: When the flags load, overflow is 1 when the two's complement result of add, subtract or negate lies outside −32768..32767. For negate this happens only for A = 0x8000. Overflow is 0 for AND and OR.
- R10: An active-low asynchronous reset clears all four flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; flags load on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the flags |
| op_a_i | input | 16 | First operand, and the destination value for negate |
| op_b_i | input | 16 | Second operand; ignored by negate |
| op_sel_i | input | 3 | Operation: 0 add, 1 sub, 2 and, 3 or, 4 negate, 5-7 undefined |
| flag_en_i | input | 1 | Flag-load enable from the controller |
| result_o | output | 16 | Combinational result |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered carry flag |
| sign_o | output | 1 | Registered sign flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The bench targets the corners where the flag logic usually goes wrong.

- Subtracting equal values must give zero with carry set. An inverted-borrow design would clear carry there.
- Negating 0 must set carry, and negating 0x8000 must set overflow. A negate built from the add path without the +1 would fail both.
- Carries that cross the 4-bit group boundaries exercise the lookahead chain. A broken group link corrupts the upper nibbles of the result.
- Idle cycles, undefined codes and a negate repeated with a different B all check that the flags and the result stay put. A design that loaded flags unconditionally, or read B during negate, would show a changed value.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned OP_W    = 3;
  localparam int unsigned GROUP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_NEG = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic sign;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         gp_o,
  output logic         gg_o
);
  logic [W-1:0] p, g;
  logic [W:0]   c;

  assign p = x_i ^ y_i;
  assign g = x_i & y_i;

  // group propagate/generate are independent of cin
  always_comb begin
    gg_o = 1'b0;
    gp_o = 1'b1;
    for (int j = 0; j < W; j++) begin
      gg_o = g[j] | (p[j] & gg_o);
      gp_o = gp_o & p[j];
    end
  end

  always_comb begin
    c[0] = cin_i;
    for (int j = 0; j < W; j++) c[j+1] = g[j] | (p[j] & c[j]);
  end

  assign sum_o = p ^ c[W-1:0];
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned W   = 16,
  parameter int unsigned GRP = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NG = W / GRP;

  logic [NG-1:0] gp, gg;
  logic [NG:0]   gc;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    cla_group #(.W(GRP)) u_grp (
      .x_i  (x_i[k*GRP +: GRP]),
      .y_i  (y_i[k*GRP +: GRP]),
      .cin_i(gc[k]),
      .sum_o(sum_o[k*GRP +: GRP]),
      .gp_o (gp[k]),
      .gg_o (gg[k])
    );
  end

  // second level: carries between groups
  always_comb begin
    gc[0] = cin_i;
    for (int k = 0; k < NG; k++) gc[k+1] = gg[k] | (gp[k] & gc[k]);
  end

  assign cout_o = gc[NG];
endmodule

// File: rtl/alu_and_unit.sv
module alu_and_unit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  assign y_o = a_i & b_i;
endmodule

// File: rtl/alu_or_unit.sv
module alu_or_unit #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  assign y_o = a_i | b_i;
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int unsigned W   = DATA_W,
  parameter int unsigned GRP = GROUP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [2:0]   op_sel_i,
  input  logic         flag_en_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         sign_o,
  output logic         ovf_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] add_x, add_y, add_sum, and_y, or_y;
  logic         add_cin, add_cout;
  logic         is_arith, is_valid;
  flags_t       flag_d, flag_q;

  always_comb begin
    is_arith = 1'b0;
    is_valid = 1'b1;
    add_x    = op_a_i;
    add_y    = op_b_i;
    add_cin  = 1'b0;
    unique case (op_sel_i)
      OP_ADD: is_arith = 1'b1;
      OP_SUB: begin
        is_arith = 1'b1;
        add_y    = ~op_b_i;
        add_cin  = 1'b1;
      end
      OP_NEG: begin
        // 0 - A through the subtract path
        is_arith = 1'b1;
        add_x    = '0;
        add_y    = ~op_a_i;
        add_cin  = 1'b1;
      end
      OP_AND, OP_OR: ;
      default: is_valid = 1'b0;
    endcase
  end

  cla_adder #(.W(W), .GRP(GRP)) u_add (
    .x_i   (add_x),
    .y_i   (add_y),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout)
  );

  alu_and_unit #(.W(W)) u_and (.a_i(op_a_i), .b_i(op_b_i), .y_o(and_y));
  alu_or_unit  #(.W(W)) u_or  (.a_i(op_a_i), .b_i(op_b_i), .y_o(or_y));

  always_comb begin
    unique case (op_sel_i)
      OP_ADD, OP_SUB, OP_NEG: result_o = add_sum;
      OP_AND:                 result_o = and_y;
      OP_OR:                  result_o = or_y;
      default:                result_o = '0;
    endcase
  end

  always_comb begin
    flag_d.zero  = ~|result_o;
    flag_d.sign  = result_o[MSB];
    flag_d.carry = is_arith & add_cout;
    flag_d.ovf   = is_arith & (add_x[MSB] == add_y[MSB]) & (add_sum[MSB] != add_x[MSB]);
  end

  flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(flag_en_i & is_valid),
    .d_i   (flag_d),
    .q_o   (flag_q)
  );

  assign zero_o  = flag_q.zero;
  assign carry_o = flag_q.carry;
  assign sign_o  = flag_q.sign;
  assign ovf_o   = flag_q.ovf;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic [2:0]   op_sel_i,
  input logic         flag_en_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         carry_o,
  input logic         sign_o,
  input logic         ovf_o
);
  logic loads;
  assign loads = flag_en_i && (op_sel_i <= 3'd4);

  a_r1_add_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i == 3'd0) |-> (result_o == W'(op_a_i + op_b_i)));

  a_r4_neg_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i == 3'd4) |-> (result_o == W'(W'(0) - op_a_i)));

  a_r5_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_sel_i > 3'd4) |-> (result_o == '0));

  a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loads |=> $stable({zero_o, carry_o, sign_o, ovf_o}));

  a_r7_zero_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loads |=> (zero_o == ($past(result_o) == '0)) && (sign_o == $past(result_o[W-1])));

  a_r8_logic_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && (op_sel_i == 3'd2 || op_sel_i == 3'd3)) |=> !carry_o);

  a_r9_logic_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && (op_sel_i == 3'd2 || op_sel_i == 3'd3)) |=> !ovf_o);
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (.*);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] op_a_i = '0, op_b_i = '0;
  logic [2:0]  op_sel_i = '0;
  logic        flag_en_i = 1'b0;
  logic [15:0] result_o;
  logic        zero_o, carry_o, sign_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_f = 4'b0000;  // {zero, carry, sign, ovf}

  always #2.5 clk_i = ~clk_i;

  alu_flag_unit uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                                output logic [15:0] r, output logic c, output logic v);
    int sa, sb, s;
    sa = int'($signed(a));
    sb = int'($signed(b));
    c = 1'b0; v = 1'b0; r = '0;
    case (op)
      3'd0: begin r = a + b; c = (int'(a) + int'(b)) > 65535; s = sa + sb; v = s > 32767 || s < -32768; end
      3'd1: begin r = a - b; c = (a >= b); s = sa - sb; v = s > 32767 || s < -32768; end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: begin r = 16'd0 - a; c = (a == 16'd0); v = (a == 16'h8000); end
      default: r = '0;
    endcase
  endfunction

  task automatic apply(string tag, logic [2:0] op, logic [15:0] a, logic [15:0] b, logic en);
    logic [15:0] r;
    logic c, v;
    @(negedge clk_i);
    op_sel_i = op; op_a_i = a; op_b_i = b; flag_en_i = en;
    model(op, a, b, r, c, v);
    #1;
    check({tag, " result"}, 32'(result_o), 32'(r));
    if (en && op <= 3'd4) exp_f = {r == 16'd0, c, r[15], v};
    @(posedge clk_i);
    #1;
    flag_en_i = 1'b0;
    check({tag, " flags"}, 32'({zero_o, carry_o, sign_o, ovf_o}), 32'(exp_f));
  endtask

  task automatic t_reset();
    #1;
    check("R10 flags in reset", 32'({zero_o, carry_o, sign_o, ovf_o}), 32'h0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_add();
    apply("R1 R7 add small", 3'd0, 16'h0003, 16'h0004, 1'b1);
    apply("R1 R8 add carry chain", 3'd0, 16'h0FFF, 16'h0001, 1'b1);
    apply("R8 R7 add wrap to zero", 3'd0, 16'hFFFF, 16'h0001, 1'b1);
    apply("R9 add pos overflow", 3'd0, 16'h7FFF, 16'h0001, 1'b1);
    apply("R9 add neg overflow", 3'd0, 16'h8000, 16'h8000, 1'b1);
  endtask

  task automatic t_sub();
    apply("R2 R8 sub equal", 3'd1, 16'h1234, 16'h1234, 1'b1);
    apply("R2 R8 sub borrow", 3'd1, 16'h0001, 16'h0002, 1'b1);
    apply("R9 sub overflow", 3'd1, 16'h8000, 16'h0001, 1'b1);
    apply("R2 sub cross nibble", 3'd1, 16'hA000, 16'h0FFF, 1'b1);
  endtask

  task automatic t_logic();
    apply("R9 setup overflow", 3'd0, 16'h7FFF, 16'h7FFF, 1'b1);
    apply("R3 R8 R9 and", 3'd2, 16'hF0F0, 16'hFF00, 1'b1);
    apply("R3 R7 and zero", 3'd2, 16'h0F0F, 16'hF0F0, 1'b1);
    apply("R3 or", 3'd3, 16'h8001, 16'h0100, 1'b1);
  endtask

  task automatic t_neg();
    logic [15:0] r1, r2;
    logic [3:0] f1;
    apply("R4 R8 neg zero", 3'd4, 16'h0000, 16'hFFFF, 1'b1);
    apply("R4 R9 neg min", 3'd4, 16'h8000, 16'h1234, 1'b1);
    apply("R4 neg one B=0", 3'd4, 16'h0001, 16'h0000, 1'b1);
    r1 = result_o; f1 = {zero_o, carry_o, sign_o, ovf_o};
    apply("R4 neg one B=ffff", 3'd4, 16'h0001, 16'hFFFF, 1'b1);
    r2 = result_o;
    check("R4 neg ignores B result", 32'(r2), 32'(r1));
    check("R4 neg ignores B flags", 32'({zero_o, carry_o, sign_o, ovf_o}), 32'(f1));
  endtask

  task automatic t_undef();
    apply("R5 setup", 3'd1, 16'h0000, 16'h0001, 1'b1);
    for (int k = 5; k < 8; k++) apply("R5 undefined op", 3'(k), 16'h0000, 16'h0000, 1'b1);
  endtask

  task automatic t_hold();
    apply("R6 setup", 3'd0, 16'h0000, 16'h0000, 1'b1);
    apply("R6 idle add", 3'd0, 16'h8000, 16'h8000, 1'b0);
    apply("R6 idle neg", 3'd4, 16'h8000, 16'h0000, 1'b0);
    apply("R6 load after idle", 3'd3, 16'h8000, 16'h0000, 1'b1);
  endtask

  task automatic t_async_reset();
    apply("R10 setup", 3'd0, 16'hFFFF, 16'hFFFF, 1'b1);
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R10 async clear", 32'({zero_o, carry_o, sign_o, ovf_o}), 32'h0);
    exp_f = 4'b0000;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #500us;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_neg();
    t_undef();
    t_hold();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule